// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block watches over a processor from inside a synchronous clock domain. A registered low-supply flag from an external comparator and a watchdog line from software are its inputs. From them it produces a reset in both polarities, a watchdog status flag and a gated chip-enable. A free-running prescaler divides the clock into ticks. Every duration is counted in ticks: the reset pulse width, the long watchdog period and the short watchdog period.

Reset is held for as long as the supply is low. It is then stretched by a fixed number of ticks once the supply recovers. Software services the watchdog by toggling its line, and either edge counts. If the line sits still for a whole period, the block fires a reset pulse of the same fixed width and drops the status flag. While the line stays still, it fires another pulse after each further period. The first period after any reset is always the long one. After software has serviced the watchdog once, a select input chooses the short or the long period. A disable input turns the watchdog off. The chip-enable is passed through while the supply is good and is forced inactive (high) while it is low.

Top module: `cpu_supervisor`

## Requirements
- R1: While `supply_low_i` is 1, `rst_n_o` is 0 from the next clock edge on.
- R2: After `supply_low_i` returns to 0, `rst_n_o` stays 0 for RESET_TICKS ticks (to within one tick) and then rises.
- R3: `rst_o` is always the inverse of `rst_n_o`.
- R4: `ce_n_o` equals `ce_n_i` while `supply_low_i` is 0 and is 1 while `supply_low_i` is 1.
- R5: Every rising and every falling edge of `wd_in_i` restarts the watchdog count. A line that toggles more often than the active period never causes a reset.
- R6: When `wd_in_i` holds one level for a full period, `rst_n_o` and `wd_ok_o` fall on the same clock edge. Reset then lasts RESET_TICKS ticks.
- R7: While the watchdog stays unserviced, the reset pulse repeats. Each new pulse starts one long period after the previous pulse has ended.
- R8: `wd_ok_o` returns to 1 after any edge of `wd_in_i`. It is also 1 while `supply_low_i` is 1.
- R9: While `wd_disable_i` is 1, the watchdog never causes a reset and never clears `wd_ok_o`.
- R10: The first watchdog period after any reset is LONG_TICKS. After the first service, `wd_short_sel_i` = 1 selects SHORT_TICKS and 0 selects LONG_TICKS.
- R11: While `srst` is 1, `rst_n_o` = 0 and `wd_ok_o` = 1. After `srst` is released, the full RESET_TICKS count runs before `rst_n_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous power-on reset, active high |
| supply_low_i | input | 1 | Registered low-supply flag from the comparator |
| wd_in_i | input | 1 | Watchdog service line, asynchronous; either edge services |
| wd_disable_i | input | 1 | 1 turns the watchdog off |
| wd_short_sel_i | input | 1 | 1 selects the short period after the first service |
| ce_n_i | input | 1 | Chip-enable in, active low |
| rst_n_o | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| wd_ok_o | output | 1 | Watchdog status, 0 after a missed period |
| ce_n_o | output | 1 | Gated chip-enable, active low |

## Verification
The assertions rely on `supply_low_i` already being synchronous to `clk`, which is why they may relate it to the very next edge. They also rely on `wd_in_i` changing no more than once per synchronizer stage time, so that each toggle yields exactly one detected edge. The bench honours both. It drives every input just after a falling clock edge and toggles the watchdog line at intervals of at least one cycle. Because the prescaler phase is free-running, the bench compares each measured duration against a window one tick wide around the nominal tick count, never against an exact cycle.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic {
        PERIOD_LONG  = 1'b0,
        PERIOD_SHORT = 1'b1
    } period_sel_e;

    function automatic int unsigned cnt_width(input int unsigned max_value);
        return (max_value < 2) ? 1 : $clog2(max_value + 1);
    endfunction

endpackage

// File: rtl/sup_tick_gen.sv
module sup_tick_gen #(
    parameter int unsigned PRESCALE = 4
) (
    input  logic clk,
    input  logic srst,
    output logic tick_o
);
    generate
        if (PRESCALE <= 1) begin : g_every_cycle
            assign tick_o = 1'b1;
        end else begin : g_divide
            localparam int unsigned PW = sup_pkg::cnt_width(PRESCALE - 1);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

            typedef struct packed {
                logic [PW-1:0] cnt;
                logic          tick;
            } tick_state_t;

            tick_state_t st_d, st_q;

            always_comb begin
                st_d      = st_q;
                st_d.tick = (st_q.cnt == LAST);
                st_d.cnt  = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (srst) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign tick_o = st_q.tick;

            assert_tick_isolated_R2: assert property (@(posedge clk) disable iff (srst)
                st_q.tick |=> !st_q.tick);
        end
    endgenerate
endmodule

// File: rtl/sup_edge_sync.sv
module sup_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic srst,
    input  logic din_i,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d.chain = {st_q.chain[STAGES-1:0], din_i};
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_o = st_q.chain[STAGES] ^ st_q.chain[STAGES-1];
endmodule

// File: rtl/sup_reset_stretch.sv
module sup_reset_stretch #(
    parameter int unsigned RESET_TICKS = 35
) (
    input  logic clk,
    input  logic srst,
    input  logic tick_i,
    input  logic supply_low_i,
    input  logic wd_expire_i,
    output logic active_o
);
    localparam int unsigned RW = sup_pkg::cnt_width(RESET_TICKS);
    localparam logic [RW-1:0] RLOAD = RW'(RESET_TICKS);

    typedef struct packed {
        logic          active;
        logic [RW-1:0] cnt;
    } stretch_state_t;

    stretch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (supply_low_i || wd_expire_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = RLOAD;
        end else if (st_q.active && tick_i) begin
            if (st_q.cnt <= 1) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            st_q.active <= 1'b1;
            st_q.cnt    <= RLOAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    assert_low_supply_holds_R1: assert property (@(posedge clk) disable iff (srst)
        supply_low_i |=> st_q.active);

    assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (srst)
        $fell(st_q.active) |-> ($past(tick_i) && !$past(supply_low_i)));
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer #(
    parameter int unsigned LONG_TICKS  = 1600,
    parameter int unsigned SHORT_TICKS = 100
) (
    input  logic clk,
    input  logic srst,
    input  logic tick_i,
    input  logic edge_i,
    input  logic disable_i,
    input  logic short_sel_i,
    input  logic rst_active_i,
    input  logic supply_low_i,
    output logic expire_o,
    output logic ok_o
);
    import sup_pkg::*;

    localparam int unsigned CW = cnt_width(LONG_TICKS - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          first;
        logic          ok;
    } wd_state_t;

    wd_state_t   st_d, st_q;
    period_sel_e period_sel;
    logic [CW-1:0] limit;
    logic        expire;

    always_comb begin
        period_sel = (st_q.first || !short_sel_i) ? PERIOD_LONG : PERIOD_SHORT;
        limit      = (period_sel == PERIOD_SHORT) ? SHORT_LAST : LONG_LAST;
        expire     = !disable_i && !rst_active_i && !edge_i && tick_i
                     && (st_q.cnt >= limit);

        st_d = st_q;
        if (rst_active_i || disable_i) begin
            st_d.cnt = '0;
            if (rst_active_i) begin
                st_d.first = 1'b1;
            end
        end else if (edge_i) begin
            st_d.cnt   = '0;
            st_d.first = 1'b0;
        end else if (tick_i) begin
            st_d.cnt = expire ? '0 : st_q.cnt + 1'b1;
        end

        if (supply_low_i || edge_i) begin
            st_d.ok = 1'b1;
        end else if (expire) begin
            st_d.ok = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            st_q.cnt   <= '0;
            st_q.first <= 1'b1;
            st_q.ok    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign expire_o = expire;
    assign ok_o     = st_q.ok;

    assert_edge_restarts_count_R5: assert property (@(posedge clk) disable iff (srst)
        edge_i |=> (st_q.cnt == '0));

    assert_count_in_range_R10: assert property (@(posedge clk) disable iff (srst)
        st_q.cnt <= LONG_LAST);

    assert_ok_on_supply_R8: assert property (@(posedge clk) disable iff (srst)
        supply_low_i |=> st_q.ok);

    assert_held_clear_in_reset_R9: assert property (@(posedge clk) disable iff (srst)
        (rst_active_i || disable_i) |=> (st_q.cnt == '0));
endmodule

// File: rtl/cpu_supervisor.sv
module cpu_supervisor #(
    parameter int unsigned PRESCALE    = 4,
    parameter int unsigned RESET_TICKS = 35,
    parameter int unsigned LONG_TICKS  = 1600,
    parameter int unsigned SHORT_TICKS = 100,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic srst,
    input  logic supply_low_i,
    input  logic wd_in_i,
    input  logic wd_disable_i,
    input  logic wd_short_sel_i,
    input  logic ce_n_i,
    output logic rst_n_o,
    output logic rst_o,
    output logic wd_ok_o,
    output logic ce_n_o
);
    logic tick;
    logic wd_edge;
    logic wd_expire;
    logic rst_active;

    sup_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk    (clk),
        .srst   (srst),
        .tick_o (tick)
    );

    sup_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .srst   (srst),
        .din_i  (wd_in_i),
        .edge_o (wd_edge)
    );

    sup_reset_stretch #(.RESET_TICKS(RESET_TICKS)) u_stretch (
        .clk          (clk),
        .srst         (srst),
        .tick_i       (tick),
        .supply_low_i (supply_low_i),
        .wd_expire_i  (wd_expire),
        .active_o     (rst_active)
    );

    sup_wd_timer #(
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_wd (
        .clk          (clk),
        .srst         (srst),
        .tick_i       (tick),
        .edge_i       (wd_edge),
        .disable_i    (wd_disable_i),
        .short_sel_i  (wd_short_sel_i),
        .rst_active_i (rst_active),
        .supply_low_i (supply_low_i),
        .expire_o     (wd_expire),
        .ok_o         (wd_ok_o)
    );

    assign rst_n_o = ~rst_active;
    assign rst_o   = rst_active;
    assign ce_n_o  = supply_low_i | ce_n_i;

    assert_expiry_drops_ok_R6: assert property (@(posedge clk) disable iff (srst)
        ($fell(rst_n_o) && !$past(supply_low_i) && !$past(srst)) |-> !wd_ok_o);

    assert_disabled_no_reset_R9: assert property (@(posedge clk) disable iff (srst)
        ($past(wd_disable_i) && !$past(supply_low_i) && !$past(srst) && $past(rst_n_o))
        |-> rst_n_o);

    assert_ok_rises_after_edge_R8: assert property (@(posedge clk) disable iff (srst)
        $past(wd_edge) |-> wd_ok_o);
endmodule

// File: tb/cpu_supervisor_bench.sv
module cpu_supervisor_bench;
    localparam int P = 2;
    localparam int R = 4;
    localparam int L = 40;
    localparam int S = 10;

    logic clk = 1'b0;
    logic srst, supply_low, wd_in, wd_dis, wd_sel, ce_n;
    logic rst_n_o, rst_o, wd_ok_o, ce_n_o;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int last_edge = 0;
    int falls = 0;
    logic prev_rstn = 1'b0;
    logic tog_en = 1'b0;
    int tog_half = 4;
    logic done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cpu_supervisor #(
        .PRESCALE(P), .RESET_TICKS(R), .LONG_TICKS(L), .SHORT_TICKS(S), .SYNC_STAGES(2)
    ) u_cpu_supervisor (
        .clk(clk), .srst(srst), .supply_low_i(supply_low), .wd_in_i(wd_in),
        .wd_disable_i(wd_dis), .wd_short_sel_i(wd_sel), .ce_n_i(ce_n),
        .rst_n_o(rst_n_o), .rst_o(rst_o), .wd_ok_o(wd_ok_o), .ce_n_o(ce_n_o)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_win(input string tag, input int act, input int lo, input int hi);
        vectors++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    // toggler for the watchdog line
    initial begin
        int tcnt = 0;
        wd_in = 1'b0;
        forever begin
            @(negedge clk);
            if (tog_en) begin
                tcnt++;
                if (tcnt >= tog_half) begin
                    tcnt = 0;
                    wd_in = ~wd_in;
                    last_edge = cyc;
                end
            end else begin
                tcnt = 0;
            end
        end
    end

    // R3 polarity monitor and fall counter
    always @(negedge clk) begin
        if (!srst) begin
            check(rst_o === ~rst_n_o, "R3 polarity", int'(rst_o), int'(~rst_n_o));
            if (prev_rstn && !rst_n_o) falls++;
            prev_rstn <= rst_n_o;
        end
    end

    task automatic cycles_until(input logic level, output int n);
        n = 0;
        while (rst_n_o !== level && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int f0;
        srst = 1'b1; supply_low = 1'b0; wd_dis = 1'b0; wd_sel = 1'b0; ce_n = 1'b1;
        repeat (5) @(negedge clk);
        // R11 reset state
        check(rst_n_o == 1'b0, "R11 rst_n in srst", int'(rst_n_o), 0);
        check(rst_o == 1'b1, "R11 rst in srst", int'(rst_o), 1);
        check(wd_ok_o == 1'b1, "R11 wd_ok in srst", int'(wd_ok_o), 1);
        tog_half = 4; tog_en = 1'b1;
        srst = 1'b0;
        cycles_until(1'b1, n);
        check_win("R11 release stretch", n, (R-1)*P, R*P+3);

        // R4 chip-enable gating, all combinations
        for (int sl = 0; sl < 2; sl++) begin
            for (int ce = 0; ce < 2; ce++) begin
                @(negedge clk);
                supply_low = sl[0]; ce_n = ce[0];
                #1;
                check(ce_n_o == (sl[0] | ce[0]), "R4 ce gating", int'(ce_n_o), int'(sl[0] | ce[0]));
            end
        end

        // R1 and R8: supply low holds reset, keeps wd_ok high
        @(negedge clk); supply_low = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(rst_n_o == 1'b0, "R1 reset while supply low", int'(rst_n_o), 0);
            check(wd_ok_o == 1'b1, "R8 wd_ok while supply low", int'(wd_ok_o), 1);
        end
        supply_low = 1'b0; ce_n = 1'b1;
        cycles_until(1'b1, n);
        check_win("R2 recovery stretch", n, (R-1)*P, R*P+3);

        // R5: toggling faster than the short period never resets
        wd_sel = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tog_half = (k == 0) ? 1 : (k == 1) ? 4 : 8;
            f0 = falls;
            repeat (300) @(negedge clk);
            check(falls == f0, "R5 serviced no reset", falls - f0, 0);
            check(rst_n_o == 1'b1, "R5 reset high while serviced", int'(rst_n_o), 1);
        end

        // R10 short period after service, R6 expiry
        tog_en = 1'b0;
        cycles_until(1'b0, n);
        check_win("R10 short timeout", cyc - last_edge, (S-1)*P, S*P+5);
        check(wd_ok_o == 1'b0, "R6 wd_ok low at expiry", int'(wd_ok_o), 0);
        cycles_until(1'b1, n);
        check_win("R6 watchdog reset width", n, (R-1)*P, R*P+3);
        // first period after reset is long despite short select
        cycles_until(1'b0, n);
        check_win("R10 first period long", n, (L-1)*P, L*P+3);
        cycles_until(1'b1, n);
        check_win("R7 repeat width", n, (R-1)*P, R*P+3);
        cycles_until(1'b0, n);
        check_win("R7 repeat interval", n, (L-1)*P, L*P+3);
        check(wd_ok_o == 1'b0, "R6 wd_ok low on repeat", int'(wd_ok_o), 0);

        // R8: edge restores wd_ok
        @(negedge clk); wd_in = ~wd_in;
        repeat (4) @(negedge clk);
        check(wd_ok_o == 1'b1, "R8 wd_ok after edge", int'(wd_ok_o), 1);

        // R8: supply low restores wd_ok after an expiry
        tog_en = 1'b0;
        cycles_until(1'b1, n);
        cycles_until(1'b0, n);
        check(wd_ok_o == 1'b0, "R6 wd_ok low again", int'(wd_ok_o), 0);
        @(negedge clk); supply_low = 1'b1;
        repeat (2) @(negedge clk);
        check(wd_ok_o == 1'b1, "R8 wd_ok on supply low", int'(wd_ok_o), 1);
        supply_low = 1'b0;
        tog_half = 4; tog_en = 1'b1;
        cycles_until(1'b1, n);
        check_win("R2 recovery after expiry", n, (R-1)*P, R*P+3);

        // R10 long period when short not selected
        wd_sel = 1'b0;
        repeat (100) @(negedge clk);
        tog_en = 1'b0;
        cycles_until(1'b0, n);
        check_win("R10 long timeout selected", cyc - last_edge, (L-1)*P, L*P+5);
        tog_en = 1'b1;
        cycles_until(1'b1, n);
        repeat (20) @(negedge clk);

        // R9: disabled watchdog never resets
        wd_dis = 1'b1; tog_en = 1'b0;
        f0 = falls;
        repeat (3*L*P) @(negedge clk);
        check(falls == f0, "R9 disabled no reset", falls - f0, 0);
        check(wd_ok_o == 1'b1, "R9 disabled keeps wd_ok", int'(wd_ok_o), 1);
        wd_dis = 1'b0; tog_en = 1'b1;
        repeat (50) @(negedge clk);
        check(rst_n_o == 1'b1, "R9 reenabled serviced", int'(rst_n_o), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule